// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualization extended capability of a PCIe physical function. It has a dword-wide configuration port: a dword index, four byte enables, write data and a write strobe. Read data comes back combinationally for the presented index. Every field carries its own write mask. Some masks move with the control state, so a field can be writable at one moment and locked the next.

The live control bits, the effective number of virtual functions and the chosen system page size drive the rest of the function directly. The ID fields, VF routing-ID layout and the supported page sizes come from parameters. The VF base address registers take their type bits and sizes from parameters as well, and a 64-bit memory BAR occupies two adjacent slots.

A synchronous function-level reset input puts all software-visible state back to its default values. The active-low asynchronous reset does the same.

Top module: `sriov_cap_regs`

## Requirements
- R1: After either reset, the control word is 0, NumVFs is 0 and System Page Size is 0x1. Each VF BAR holds only its type byte: 0x0000000C for slot 0, 0x00000001 for slot 3 and 0 for the others.
- R2: Writes to the control word (dword 2) store only VF enable (bit 0), VF memory-space enable (bit 3) and ARI hierarchy (bit 4). Every other bit reads 0.
- R3: While VF enable is clear, a write can set VF enable only if NumVFs is no greater than TotalVFs (8). Bits 3 and 4 are written regardless, and a set VF enable can always be cleared.
- R4: NumVFs (dword 4, bits 15:0) is fully writable while VF enable is clear. Writes to it are ignored while VF enable is set. Bits 31:16 read 0.
- R5: These read-only dwords hold parameter values and ignore writes. Dword 3 is InitialVFs in [15:0] and TotalVFs in [31:16], both 8. Dword 5 is VF offset in [15:0] and stride in [31:16], both 1. Dword 6 is the VF device ID 0xA0F1 in [31:16]. Dword 7 is the supported page-size mask 0x553.
- R6: System Page Size (dword 8) stores only the bits set in the supported mask 0x553.
- R7: A byte lane whose byte enable is 0 keeps its old value on every writable field.
- R8: Each VF BAR (dwords 9 to 14) has write mask ~(size-1). Slot 0 is a 64-bit 16 KB memory BAR with mask 0xFFFFC000, and slot 1 is its upper half with mask 0xFFFFFFFF. Slot 2 is 4 KB with mask 0xFFFFF000, slot 3 is 32-byte I/O with mask 0xFFFFFFE0, and slots 4 and 5 are unimplemented with mask 0.
- R9: A function-level reset gives the R1 state in the next cycle, even when a write is presented in the same cycle.
- R10: The control outputs follow the stored bits. num_vfs_o equals NumVFs while VF enable is set and is 0 otherwise. sys_pgsize_o equals the stored page size.
- R11: Dword indices 16 and above read 0, and writes to them change no state. In-range reserved dwords (1, 15) also read 0.
- R12: Dword 0 reads 0x00010010: capability ID 0x0010 in [15:0], version 1 in [19:16] and next pointer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flr_i | input | 1 | Synchronous function-level reset |
| cfg_addr_i | input | 6 | Dword index within the capability |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_we_i | input | 1 | Write strobe |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| vf_en_o | output | 1 | VF enable |
| vf_mse_o | output | 1 | VF memory-space enable |
| ari_hier_o | output | 1 | ARI hierarchy |
| num_vfs_o | output | 16 | Effective VF count |
| sys_pgsize_o | output | 32 | Selected system page size |

## Verification
The function-level reset and a configuration write can land in the same cycle. The bench drives flr_i together with writes that would otherwise set control bits or change NumVFs, both in directed steps and at random. It then reads the registers back and expects the full reset state, with no trace of the write. A second overlap is the NumVFs lock against the enable check. The bench sets VF enable at the boundary NumVFs of 8 and one above it, then writes NumVFs while enabled and expects the old count to hold.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;
  localparam int unsigned CAP_DW    = 16;
  localparam int unsigned DW_HDR    = 0;
  localparam int unsigned DW_CTRL   = 2;
  localparam int unsigned DW_VFCNT  = 3;
  localparam int unsigned DW_NUMVF  = 4;
  localparam int unsigned DW_RID    = 5;
  localparam int unsigned DW_DEVID  = 6;
  localparam int unsigned DW_SUPPG  = 7;
  localparam int unsigned DW_SYSPG  = 8;
  localparam int unsigned DW_BAR0   = 9;

  localparam int unsigned CTRL_VFE  = 0;
  localparam int unsigned CTRL_MSE  = 3;
  localparam int unsigned CTRL_ARI  = 4;

  localparam logic [15:0] EXT_CAP_ID = 16'h0010;
  localparam logic [3:0]  CAP_VER    = 4'h1;

  function automatic logic [31:0] masked_wr(input logic [31:0] old_v,
                                            input logic [31:0] wd,
                                            input logic [31:0] mask,
                                            input logic [3:0]  be);
    logic [31:0] lane;
    for (int b = 0; b < 4; b++) lane[b*8 +: 8] = {8{be[b]}};
    return (old_v & ~(mask & lane)) | (wd & mask & lane);
  endfunction

  function automatic logic is_mem64(input logic [7:0] ty, input logic [5:0] lg);
    return (lg != 6'd0) && !ty[0] && (ty[2:1] == 2'b10);
  endfunction

  // upper half of a 64-bit BAR takes the high dword of the previous slot's mask
  function automatic logic [31:0] bar_wmask(input logic [7:0] ty, input logic [5:0] lg,
                                            input logic [7:0] pty, input logic [5:0] plg,
                                            input logic has_prev);
    logic [63:0] m;
    if (has_prev && is_mem64(pty, plg)) begin
      m = ~((64'd1 << plg) - 64'd1);
      return m[63:32];
    end
    if (lg == 6'd0) return 32'h0;
    m = ~((64'd1 << lg) - 64'd1);
    if (ty[0]) return m[31:0] & 32'hFFFF_FFFC;
    return m[31:0] & 32'hFFFF_FFF0;
  endfunction
endpackage

// File: rtl/sriov_ctrl_regs.sv
module sriov_ctrl_regs
  import sriov_cap_pkg::*;
#(
  parameter logic [15:0] TOTAL_VFS = 16'd8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flr_i,
  input  logic        ctrl_we_i,
  input  logic        num_we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_q_o,
  output logic [31:0] num_q_o
);
  logic [31:0] ctrl_q, num_q, ctrl_mask, num_mask;
  logic        vfe_q;

  assign vfe_q = ctrl_q[CTRL_VFE];

  always_comb begin
    ctrl_mask = '0;
    ctrl_mask[CTRL_MSE] = 1'b1;
    ctrl_mask[CTRL_ARI] = 1'b1;
    ctrl_mask[CTRL_VFE] = vfe_q || (num_q[15:0] <= TOTAL_VFS);
    num_mask  = vfe_q ? 32'h0 : 32'h0000_FFFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      num_q  <= '0;
    end else if (flr_i) begin
      ctrl_q <= '0;
      num_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= masked_wr(ctrl_q, wdata_i, ctrl_mask, be_i);
      if (num_we_i)  num_q  <= masked_wr(num_q, wdata_i, num_mask, be_i);
    end
  end

  assign ctrl_q_o = ctrl_q;
  assign num_q_o  = num_q;
endmodule

// File: rtl/sriov_pgsize_reg.sv
module sriov_pgsize_reg
  import sriov_cap_pkg::*;
#(
  parameter logic [31:0] SUP_PGSIZE = 32'h0000_0553
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flr_i,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] pg_q_o
);
  logic [31:0] pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pg_q <= 32'h1;
    else if (flr_i)   pg_q <= 32'h1;
    else if (we_i)    pg_q <= masked_wr(pg_q, wdata_i, SUP_PGSIZE, be_i);
  end

  assign pg_q_o = pg_q;
endmodule

// File: rtl/sriov_vfbar_regs.sv
module sriov_vfbar_regs
  import sriov_cap_pkg::*;
#(
  parameter int unsigned            NUM_BARS  = 6,
  parameter logic [NUM_BARS*8-1:0]  BAR_TYPES = '0,
  parameter logic [NUM_BARS*6-1:0]  BAR_LOG2  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flr_i,
  input  logic [NUM_BARS-1:0]      we_i,
  input  logic [3:0]               be_i,
  input  logic [31:0]              wdata_i,
  output logic [NUM_BARS-1:0][31:0] bar_o
);
  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam int unsigned PI    = (i > 0) ? i - 1 : 0;
    localparam logic [7:0]  TY    = BAR_TYPES[i*8 +: 8];
    localparam logic [5:0]  LG    = BAR_LOG2[i*6 +: 6];
    localparam logic [31:0] MASK  = bar_wmask(TY, LG, BAR_TYPES[PI*8 +: 8],
                                              BAR_LOG2[PI*6 +: 6], i > 0);
    localparam logic [31:0] RSTV  = (LG != 6'd0) ? {24'h0, TY} : 32'h0;
    logic [31:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= RSTV;
      else if (flr_i)  q <= RSTV;
      else if (we_i[i]) q <= masked_wr(q, wdata_i, MASK, be_i);
    end

    assign bar_o[i] = q;
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter int unsigned           ADDR_W      = 6,
  parameter logic [15:0]           TOTAL_VFS   = 16'd8,
  parameter logic [15:0]           INITIAL_VFS = 16'd8,
  parameter logic [15:0]           VF_OFFSET   = 16'd1,
  parameter logic [15:0]           VF_STRIDE   = 16'd1,
  parameter logic [15:0]           VF_DEV_ID   = 16'hA0F1,
  parameter logic [31:0]           SUP_PGSIZE  = 32'h0000_0553,
  parameter int unsigned           NUM_BARS    = 6,
  parameter logic [NUM_BARS*8-1:0] BAR_TYPES   = 48'h00_00_01_00_00_0C,
  parameter logic [NUM_BARS*6-1:0] BAR_LOG2    = {6'd0, 6'd0, 6'd5, 6'd12, 6'd0, 6'd14}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              vf_en_o,
  output logic              vf_mse_o,
  output logic              ari_hier_o,
  output logic [15:0]       num_vfs_o,
  output logic [31:0]       sys_pgsize_o
);
  localparam int unsigned BAR_END = DW_BAR0 + NUM_BARS;

  logic [31:0]                ctrl_q, num_q, pg_q;
  logic [NUM_BARS-1:0][31:0]  bar_q;
  logic [NUM_BARS-1:0]        bar_we;
  logic                       ctrl_we, num_we, pg_we;

  assign ctrl_we = cfg_we_i && (cfg_addr_i == ADDR_W'(DW_CTRL));
  assign num_we  = cfg_we_i && (cfg_addr_i == ADDR_W'(DW_NUMVF));
  assign pg_we   = cfg_we_i && (cfg_addr_i == ADDR_W'(DW_SYSPG));

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar_we
    assign bar_we[i] = cfg_we_i && (cfg_addr_i == ADDR_W'(DW_BAR0 + i));
  end

  sriov_ctrl_regs #(.TOTAL_VFS(TOTAL_VFS)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flr_i(flr_i),
    .ctrl_we_i(ctrl_we), .num_we_i(num_we),
    .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .ctrl_q_o(ctrl_q), .num_q_o(num_q)
  );

  sriov_pgsize_reg #(.SUP_PGSIZE(SUP_PGSIZE)) pg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flr_i(flr_i), .we_i(pg_we),
    .be_i(cfg_be_i), .wdata_i(cfg_wdata_i), .pg_q_o(pg_q)
  );

  sriov_vfbar_regs #(.NUM_BARS(NUM_BARS), .BAR_TYPES(BAR_TYPES), .BAR_LOG2(BAR_LOG2)) bar_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flr_i(flr_i), .we_i(bar_we),
    .be_i(cfg_be_i), .wdata_i(cfg_wdata_i), .bar_o(bar_q)
  );

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      ADDR_W'(DW_HDR):   cfg_rdata_o = {12'h000, CAP_VER, EXT_CAP_ID};
      ADDR_W'(DW_CTRL):  cfg_rdata_o = ctrl_q;
      ADDR_W'(DW_VFCNT): cfg_rdata_o = {TOTAL_VFS, INITIAL_VFS};
      ADDR_W'(DW_NUMVF): cfg_rdata_o = num_q;
      ADDR_W'(DW_RID):   cfg_rdata_o = {VF_STRIDE, VF_OFFSET};
      ADDR_W'(DW_DEVID): cfg_rdata_o = {VF_DEV_ID, 16'h0};
      ADDR_W'(DW_SUPPG): cfg_rdata_o = SUP_PGSIZE;
      ADDR_W'(DW_SYSPG): cfg_rdata_o = pg_q;
      default: begin
        for (int k = DW_BAR0; k < BAR_END; k++)
          if (cfg_addr_i == ADDR_W'(k)) cfg_rdata_o = bar_q[k - DW_BAR0];
      end
    endcase
  end

  assign vf_en_o      = ctrl_q[CTRL_VFE];
  assign vf_mse_o     = ctrl_q[CTRL_MSE];
  assign ari_hier_o   = ctrl_q[CTRL_ARI];
  assign num_vfs_o    = ctrl_q[CTRL_VFE] ? num_q[15:0] : 16'h0;
  assign sys_pgsize_o = pg_q;
endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter logic [15:0] TOTAL_VFS  = 16'd8,
  parameter logic [31:0] SUP_PGSIZE = 32'h0000_0553
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flr_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              vf_en_o,
  input logic              vf_mse_o,
  input logic              ari_hier_o,
  input logic [15:0]       num_vfs_o,
  input logic [31:0]       sys_pgsize_o,
  input logic [31:0]       num_q
);
  // R3
  vfe_rise_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vf_en_o) |-> (num_q[15:0] <= TOTAL_VFS));

  // R4
  num_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vf_en_o && !flr_i) |=> (num_q == $past(num_q)));

  // R9
  flr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flr_i |=> (!vf_en_o && !vf_mse_o && !ari_hier_o && num_q == 32'h0 && sys_pgsize_o == 32'h1));

  // R6
  pgsize_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_pgsize_o & ~SUP_PGSIZE) == 32'h0);

  // R10
  num_out_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_en_o |-> (num_vfs_o <= TOTAL_VFS));

  // R11
  out_of_range_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i >= ADDR_W'(16)) |-> (cfg_rdata_o == 32'h0));
endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(
  .ADDR_W(ADDR_W), .TOTAL_VFS(TOTAL_VFS), .SUP_PGSIZE(SUP_PGSIZE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .flr_i(flr_i), .cfg_addr_i(cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o), .vf_en_o(vf_en_o), .vf_mse_o(vf_mse_o),
  .ari_hier_o(ari_hier_o), .num_vfs_o(num_vfs_o), .sys_pgsize_o(sys_pgsize_o),
  .num_q(num_q)
);

// File: tb/sriov_cap_regs_tb_top.sv
`timescale 1ns/1ps
module sriov_cap_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flr_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_rdata_o;
  logic        vf_en_o, vf_mse_o, ari_hier_o;
  logic [15:0] num_vfs_o;
  logic [31:0] sys_pgsize_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of software-visible state
  logic        m_vfe, m_mse, m_ari;
  logic [15:0] m_num;
  logic [31:0] m_pg;
  logic [31:0] m_bar [6];

  localparam logic [31:0] BAR_MASK [6] = '{32'hFFFF_C000, 32'hFFFF_FFFF, 32'hFFFF_F000,
                                           32'hFFFF_FFE0, 32'h0, 32'h0};
  localparam logic [31:0] BAR_RST  [6] = '{32'hC, 32'h0, 32'h0, 32'h1, 32'h0, 32'h0};

  always #2 clk = ~clk;

  sriov_cap_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flr_i(flr_i), .cfg_addr_i(cfg_addr_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_we_i(cfg_we_i),
    .cfg_rdata_o(cfg_rdata_o), .vf_en_o(vf_en_o), .vf_mse_o(vf_mse_o),
    .ari_hier_o(ari_hier_o), .num_vfs_o(num_vfs_o), .sys_pgsize_o(sys_pgsize_o)
  );

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] l;
    for (int b = 0; b < 4; b++) l[b*8 +: 8] = {8{be[b]}};
    return l;
  endfunction

  function automatic logic [31:0] apply(input logic [31:0] o, d, m, input logic [3:0] be);
    return (o & ~(m & lanes(be))) | (d & m & lanes(be));
  endfunction

  task automatic model_reset();
    m_vfe = 0; m_mse = 0; m_ari = 0; m_num = 0; m_pg = 32'h1;
    for (int i = 0; i < 6; i++) m_bar[i] = BAR_RST[i];
  endtask

  task automatic model_wr(input int a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] cm, nv;
    case (a)
      2: begin
        cm = 32'h18 | ((m_vfe || m_num <= 16'd8) ? 32'h1 : 32'h0);
        nv = apply({27'h0, m_ari, m_mse, 2'b00, m_vfe}, d, cm, be);
        m_vfe = nv[0]; m_mse = nv[3]; m_ari = nv[4];
      end
      4: begin
        nv = apply({16'h0, m_num}, d, m_vfe ? 32'h0 : 32'hFFFF, be);
        m_num = nv[15:0];
      end
      8: m_pg = apply(m_pg, d, 32'h553, be);
      9, 10, 11, 12, 13, 14: m_bar[a-9] = apply(m_bar[a-9], d, BAR_MASK[a-9], be);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return 32'h0001_0010;
      2: return {27'h0, m_ari, m_mse, 2'b00, m_vfe};
      3: return 32'h0008_0008;
      4: return {16'h0, m_num};
      5: return 32'h0001_0001;
      6: return 32'hA0F1_0000;
      7: return 32'h0000_0553;
      8: return m_pg;
      9, 10, 11, 12, 13, 14: return m_bar[a-9];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    cfg_addr_i = 6'(a);
    #1;
    chk(req, $sformatf("read dw %0d", a), cfg_rdata_o, exp_rd(a));
  endtask

  task automatic out_chk(input string req);
    @(negedge clk);
    #1;
    chk(req, "ctrl outs", {29'h0, vf_en_o, vf_mse_o, ari_hier_o}, {29'h0, m_vfe, m_mse, m_ari});
    chk(req, "num_vfs_o", {16'h0, num_vfs_o}, {16'h0, m_vfe ? m_num : 16'h0});
    chk(req, "sys_pgsize_o", sys_pgsize_o, m_pg);
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr_i = 6'(a); cfg_be_i = be; cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
    model_wr(a, be, d);
  endtask

  task automatic flr_pulse(input logic with_wr, input int a, input logic [31:0] d);
    @(negedge clk);
    flr_i = 1'b1;
    cfg_we_i = with_wr; cfg_addr_i = 6'(a); cfg_be_i = 4'hF; cfg_wdata_i = d;
    @(negedge clk);
    flr_i = 1'b0; cfg_we_i = 1'b0;
    model_reset();
  endtask

  task automatic dump(input string req);
    for (int a = 0; a < 20; a++) rd_chk(a, req);
    rd_chk(63, req);
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 R12 R5 R11: reset image
    dump("R1");
    rd_chk(0, "R12");
    out_chk("R1");

    // R2: only three control bits stick
    wr(2, 4'hF, 32'hFFFF_FFFF);
    rd_chk(2, "R2");
    chk("R2", "ctrl word", cfg_rdata_o, 32'h19);
    out_chk("R10");

    // R4: NumVFs locked while enabled
    wr(4, 4'hF, 32'h5);
    rd_chk(4, "R4");
    chk("R4", "num locked", cfg_rdata_o, 32'h0);
    wr(2, 4'hF, 32'h0);
    wr(4, 4'hF, 32'hFFFF_0005);
    rd_chk(4, "R4");
    wr(2, 4'hF, 32'h1);
    out_chk("R10");
    chk("R10", "num out", {16'h0, num_vfs_o}, 32'h5);

    // R3: enable refused above TotalVFs, MSE/ARI still taken
    wr(2, 4'hF, 32'h0);
    wr(4, 4'hF, 32'h9);
    wr(2, 4'hF, 32'h19);
    rd_chk(2, "R3");
    chk("R3", "vfe refused", cfg_rdata_o, 32'h18);
    wr(4, 4'hF, 32'h8);
    wr(2, 4'hF, 32'h19);
    rd_chk(2, "R3");
    chk("R3", "vfe at boundary", cfg_rdata_o, 32'h19);
    out_chk("R3");

    // R7: byte lanes
    wr(2, 4'hE, 32'h0);
    rd_chk(2, "R7");
    wr(2, 4'hF, 32'h0);
    wr(4, 4'h2, 32'h0000_1234);
    rd_chk(4, "R7");
    chk("R7", "lane keep", cfg_rdata_o, 32'h0000_1208);

    // R6: page size
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd_chk(8, "R6");
    chk("R6", "pgsize mask", cfg_rdata_o, 32'h553);
    wr(8, 4'hF, 32'h2);
    rd_chk(8, "R6");

    // R8: BAR masks
    for (int i = 9; i < 15; i++) wr(i, 4'hF, 32'hFFFF_FFFF);
    for (int i = 9; i < 15; i++) rd_chk(i, "R8");

    // R5: read-only fields
    for (int i = 0; i < 8; i++) if (i != 2 && i != 4) wr(i, 4'hF, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) rd_chk(i, "R5");

    // R11: out-of-range writes do nothing
    wr(20, 4'hF, 32'hFFFF_FFFF);
    wr(63, 4'hF, 32'hFFFF_FFFF);
    wr(15, 4'hF, 32'hFFFF_FFFF);
    dump("R11");

    // R9: reset wins over a same-cycle write
    flr_pulse(1'b1, 2, 32'h19);
    dump("R9");
    out_chk("R9");
    wr(4, 4'hF, 32'h3);
    flr_pulse(1'b1, 4, 32'h7);
    rd_chk(4, "R9");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned r, a;
      logic [31:0] d;
      r = $urandom % 100;
      a = $urandom % 20;
      if (r < 30) a = 2;
      else if (r < 50) a = 4;
      d = $urandom;
      if (a == 4 && ($urandom % 4) != 0) d = $urandom % 12;
      if (a == 2 && ($urandom % 2) != 0) d = d | 32'h1;
      if (r >= 95) flr_pulse(($urandom % 2) != 0, int'(a), d);
      else wr(int'(a), 4'($urandom), d);
      rd_chk(int'($urandom % 20), "R7");
      rd_chk(2, "R3");
      rd_chk(4, "R4");
      if (n % 8 == 0) out_chk("R10");
    end
    dump("R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule